// File: doc/BRIEF.md
# Host Bus Read-Latency Bridge

This block connects a host processor's asynchronous, SRAM-like memory bus to an internal register bus that runs on the system clock. The host's chip select and its read and write strobes are brought into the system clock domain. Each host access then becomes a single-cycle internal enable. An address decoder steers writes to one of several core slots. For reads, it picks the data of the addressed core through a multiplexer that is registered by default. Host accesses are 32-bit words. Bus line N carries host byte-address bit N+2, so the bus has no lines for the two lowest byte bits.

The host has no wait or ready handshake. Read data is therefore captured a fixed number of system cycles after the internal read enable, and the delay matches the selector multiplexer: 2 cycles when it is registered, 1 when it is combinational. The captured word is held on the host data output until the next capture. A host that samples early in its strobe sees the word fetched by its previous read, so software reads each word twice to get current data. A parameter masks the upper address lines, so the default 24-line bus decodes only 19 lines.

Top module: `hostbus_bridge_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `host_rdata` is 0 and `core_wr_stb` is all zeros. A reset in mid-operation clears the held read word back to 0.
- R2: Every host write access (chip select and write strobe both low) produces exactly one cycle of `core_wr_stb`, however long the strobe is held. Only one bit of `core_wr_stb` is ever high at a time.
- R3: During that strobe cycle, `core_addr` equals host address lines 15:0 and `core_wdata` equals the host write word.
- R4: With the default capture delay of 2, a new read word appears on `host_rdata` after the 5th rising clock edge following the assertion of the host read condition. That count is two synchroniser edges, one edge to issue the enable, one selector register edge and one capture edge. After the 4th edge the old word is still present.
- R5: With the capture delay set to 1, which implies a combinational selector, the new read word appears after the 4th rising edge. This is one edge earlier than in R4.
- R6: `host_rdata` keeps its last captured value until the next read capture. Writes do not change it. A sample taken as a host read begins returns the word of the previous read.
- R7: Slot codes 4 to 7 on address lines 18:16 are unmapped. A read there returns 0xDEADBEEF, and a write there raises no strobe.
- R8: Address lines 23:19 are ignored. Two addresses that differ only in those lines give the same read data.
- R9: Address lines 18:16 select the core slot. Slot k's read word is taken from `core_rdata[32k+31:32k]`, and a write raises `core_wr_stb[k]`.
- R10: When `host_cs_n` is high, low read or write strobes cause no strobe and no change of `host_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| host_cs_n | input | 1 | Host chip select, active low, asynchronous |
| host_oe_n | input | 1 | Host read strobe, active low, asynchronous |
| host_we_n | input | 1 | Host write strobe, active low, asynchronous |
| host_addr | input | 24 | Host word-address lines |
| host_wdata | input | 32 | Host write word |
| host_rdata | output | 32 | Held read word returned to the host |
| core_addr | output | 16 | Register address inside the selected core |
| core_wdata | output | 32 | Write word presented to the cores |
| core_wr_stb | output | 4 | One-hot, single-cycle write strobe per core slot |
| core_rdata | input | 128 | Read words of all core slots, slot k at bits 32k+31:32k |

## Verification
Reads are driven from a table of addresses. The table covers every mapped slot, two unmapped slot codes, and two addresses that have high masked lines set on top of a mapped address. A correct read therefore separates slot decoding from masking and from the unmapped fallback. Each read is sampled at three points: as the strobe starts, to see the stale word; after four edges, where the combinational-selector copy must already be current and the registered copy must not; and after five edges. These samples separate the two latency settings by exactly one cycle. Writes are held for many cycles to each slot, to an unmapped slot and with chip select high, so that one-shot strobing, decode and gating are each shown in isolation.

// File: rtl/hb_pkg.sv
package hb_pkg;
  localparam logic [31:0] HB_UNMAPPED_WORD = 32'hDEAD_BEEF;
endpackage

// File: rtl/hb_sync_edge.sv
module hb_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], lvl};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/hb_bridge.sv
module hb_bridge #(
  parameter int ADDR_W      = 24,
  parameter int EFF_W       = 19,
  parameter int DATA_W      = 32,
  parameter int RD_LAT      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] sel_rdata,
  output logic              rd_en,
  output logic              wr_en,
  output logic [EFF_W-1:0]  addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] host_rdata
);
  localparam logic [ADDR_W-1:0] ADDR_MASK = {ADDR_W{1'b1}} >> (ADDR_W - EFF_W);

  logic rd_rise, wr_rise, cap;

  hb_sync_edge #(.STAGES(SYNC_STAGES)) u_rd_sync (
    .clk(clk), .rst(rst), .lvl(~cs_n & ~oe_n), .rise(rd_rise));
  hb_sync_edge #(.STAGES(SYNC_STAGES)) u_wr_sync (
    .clk(clk), .rst(rst), .lvl(~cs_n & ~we_n), .rise(wr_rise));

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_en   <= 1'b0;
      wr_en   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      rd_en <= rd_rise;
      wr_en <= wr_rise;
      if (rd_rise | wr_rise) addr_q <= EFF_W'(addr & ADDR_MASK);
      if (wr_rise)           wdata_q <= wdata;
    end
  end

  generate
    if (RD_LAT == 1) begin : g_cap_now
      assign cap = rd_en;
    end else begin : g_cap_pipe
      logic [RD_LAT-2:0] pipe;
      always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else begin
          pipe[0] <= rd_en;
          for (int i = 1; i < RD_LAT - 1; i++) pipe[i] <= pipe[i-1];
        end
      end
      assign cap = pipe[RD_LAT-2];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)      host_rdata <= '0;
    else if (cap) host_rdata <= sel_rdata;
  end

  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> !rd_en); // R4
  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en); // R2
  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (rst)
    !cap |=> $stable(host_rdata)); // R6
endmodule

// File: rtl/hb_core_sel.sv
module hb_core_sel
  import hb_pkg::*;
#(
  parameter int EFF_W   = 19,
  parameter int SEL_W   = 3,
  parameter int NCORE   = 4,
  parameter int DATA_W  = 32,
  parameter bit REG_MUX = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rd_en,
  input  logic                    wr_en,
  input  logic [EFF_W-1:0]        addr,
  input  logic [NCORE*DATA_W-1:0] core_rdata,
  output logic [NCORE-1:0]        core_wr_stb,
  output logic [EFF_W-SEL_W-1:0]  core_addr,
  output logic [DATA_W-1:0]       sel_rdata
);
  localparam int LOC_W = EFF_W - SEL_W;
  localparam logic [DATA_W-1:0] MISS = DATA_W'(HB_UNMAPPED_WORD);

  logic [SEL_W-1:0]  slot;
  logic [DATA_W-1:0] mux_val;

  assign slot      = addr[EFF_W-1 -: SEL_W];
  assign core_addr = addr[LOC_W-1:0];

  always_comb begin
    mux_val = MISS;
    for (int k = 0; k < NCORE; k++)
      if (slot == SEL_W'(k)) mux_val = core_rdata[k*DATA_W +: DATA_W];
  end

  generate
    for (genvar k = 0; k < NCORE; k++) begin : g_wstb
      assign core_wr_stb[k] = wr_en & (slot == SEL_W'(k));
    end

    if (REG_MUX) begin : g_reg_mux
      logic [DATA_W-1:0] sel_q;
      always_ff @(posedge clk) begin
        if (rst)        sel_q <= '0;
        else if (rd_en) sel_q <= mux_val;
      end
      assign sel_rdata = sel_q;

      AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (int'(slot) >= NCORE)) |=> (sel_rdata == MISS)); // R7
    end else begin : g_comb_mux
      assign sel_rdata = mux_val;
    end
  endgenerate

  AST_WSTB_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(core_wr_stb)); // R2
  AST_NO_UNMAPPED_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (int'(slot) >= NCORE)) |-> (core_wr_stb == '0)); // R7
endmodule

// File: rtl/hostbus_bridge_top.sv
module hostbus_bridge_top #(
  parameter int ADDR_W    = 24,
  parameter int MASK_BITS = 5,
  parameter int SEL_W     = 3,
  parameter int NCORE     = 4,
  parameter int DATA_W    = 32,
  parameter int RD_LAT    = 2,
  localparam int EFF_W    = ADDR_W - MASK_BITS,
  localparam int LOC_W    = EFF_W - SEL_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    host_cs_n,
  input  logic                    host_oe_n,
  input  logic                    host_we_n,
  input  logic [ADDR_W-1:0]       host_addr,
  input  logic [DATA_W-1:0]       host_wdata,
  output logic [DATA_W-1:0]       host_rdata,
  output logic [LOC_W-1:0]        core_addr,
  output logic [DATA_W-1:0]       core_wdata,
  output logic [NCORE-1:0]        core_wr_stb,
  input  logic [NCORE*DATA_W-1:0] core_rdata
);
  localparam bit REG_MUX = (RD_LAT >= 2);

  logic              rd_en, wr_en;
  logic [EFF_W-1:0]  addr_q;
  logic [DATA_W-1:0] sel_rdata;

  hb_bridge #(
    .ADDR_W(ADDR_W), .EFF_W(EFF_W), .DATA_W(DATA_W),
    .RD_LAT(RD_LAT), .SYNC_STAGES(2)
  ) u_bridge (
    .clk(clk), .rst(rst), .cs_n(host_cs_n), .oe_n(host_oe_n), .we_n(host_we_n),
    .addr(host_addr), .wdata(host_wdata), .sel_rdata(sel_rdata),
    .rd_en(rd_en), .wr_en(wr_en), .addr_q(addr_q), .wdata_q(core_wdata),
    .host_rdata(host_rdata));

  hb_core_sel #(
    .EFF_W(EFF_W), .SEL_W(SEL_W), .NCORE(NCORE), .DATA_W(DATA_W), .REG_MUX(REG_MUX)
  ) u_sel (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr_q),
    .core_rdata(core_rdata), .core_wr_stb(core_wr_stb), .core_addr(core_addr),
    .sel_rdata(sel_rdata));
endmodule

// File: tb/hostbus_bridge_top_test.sv
module hostbus_bridge_top_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [23:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata_c, cwdata, cwdata_c;
  logic [15:0] caddr, caddr_c;
  logic [3:0]  stb, stb_c;
  logic [127:0] crd, crd_c;

  int checks = 0, errors = 0;
  int stb_cycles = 0;
  logic [3:0]  last_stb;
  logic [15:0] last_addr;
  logic [31:0] last_data;
  bit done = 1'b0;

  always #2 clk = ~clk;

  always_comb begin
    for (int k = 0; k < 4; k++) begin
      crd[k*32 +: 32]   = {8'(k), 8'hA5, caddr};
      crd_c[k*32 +: 32] = {8'(k), 8'hA5, caddr_c};
    end
  end

  hostbus_bridge_top uut (
    .clk(clk), .rst(rst), .host_cs_n(cs_n), .host_oe_n(oe_n), .host_we_n(we_n),
    .host_addr(addr), .host_wdata(wdata), .host_rdata(rdata),
    .core_addr(caddr), .core_wdata(cwdata), .core_wr_stb(stb), .core_rdata(crd));

  hostbus_bridge_top #(.RD_LAT(1)) uut_comb (
    .clk(clk), .rst(rst), .host_cs_n(cs_n), .host_oe_n(oe_n), .host_we_n(we_n),
    .host_addr(addr), .host_wdata(wdata), .host_rdata(rdata_c),
    .core_addr(caddr_c), .core_wdata(cwdata_c), .core_wr_stb(stb_c), .core_rdata(crd_c));

  always @(negedge clk) begin
    if (stb != '0) begin
      stb_cycles++;
      last_stb  = stb;
      last_addr = caddr;
      last_data = cwdata;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  typedef struct packed {
    logic [23:0] a;
    logic [31:0] e;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{24'h000010, 32'h00A50010},  // R9 slot 0
    '{24'h011234, 32'h01A51234},  // R9 slot 1
    '{24'h02BEEF, 32'h02A5BEEF},  // R9 slot 2
    '{24'h030001, 32'h03A50001},  // R9 slot 3
    '{24'h040000, 32'hDEADBEEF},  // R7 slot code 4
    '{24'h07FFFF, 32'hDEADBEEF},  // R7 slot code 7
    '{24'hF80005, 32'h00A50005},  // R8 high lines set
    '{24'h8B4321, 32'h03A54321}   // R8 high lines set
  };

  task automatic do_read(input logic [23:0] a, input logic [31:0] e, input logic [31:0] prev);
    addr = a; cs_n = 1'b0; oe_n = 1'b0;
    #1;
    chk(rdata == prev, "R6 stale word at read start", rdata, prev);
    cyc(4);
    chk(rdata_c == e, "R5 comb selector after 4 edges", rdata_c, e);
    chk(rdata == prev, "R4 old word after 4 edges", rdata, prev);
    cyc(1);
    chk(rdata == e, "R4 new word after 5 edges", rdata, e);
    cyc(3);
    cs_n = 1'b1; oe_n = 1'b1;
    cyc(4);
  endtask

  task automatic do_write(input logic [23:0] a, input logic [31:0] d, input logic cs);
    stb_cycles = 0;
    addr = a; wdata = d; cs_n = cs; we_n = 1'b0;
    cyc(12);
    cs_n = 1'b1; we_n = 1'b1;
    cyc(4);
  endtask

  initial begin
    logic [31:0] prev;
    cyc(1);
    chk(rdata == 32'h0, "R1 rdata in reset", rdata, 32'h0);
    chk(stb == 4'h0, "R1 no strobe in reset", 32'(stb), 32'h0);
    cyc(2);
    rst = 1'b0;
    cyc(1);
    chk(rdata == 32'h0, "R1 rdata after reset", rdata, 32'h0);
    chk(stb == 4'h0, "R1 no strobe after reset", 32'(stb), 32'h0);

    prev = 32'h0;
    for (int i = 0; i < 8; i++) begin
      do_read(TBL[i].a, TBL[i].e, prev);
      prev = TBL[i].e;
    end

    for (int k = 0; k < 4; k++) begin
      logic [31:0] d;
      d = 32'hC0DE_0000 + 32'(k * 17);
      do_write({5'h1F, 3'(k), 16'h0100 + 16'(k)}, d, 1'b0);
      chk(stb_cycles == 1, "R2 single strobe cycle", 32'(stb_cycles), 32'd1);
      chk(last_stb == 4'(1 << k), "R9 write slot strobe", 32'(last_stb), 32'(1 << k));
      chk(last_addr == 16'h0100 + 16'(k), "R3 core address", 32'(last_addr), 32'(16'h0100 + 16'(k)));
      chk(last_data == d, "R3 core write word", last_data, d);
      chk(rdata == prev, "R6 write leaves read word", rdata, prev);
    end

    do_write(24'h050042, 32'h1111_2222, 1'b0);
    chk(stb_cycles == 0, "R7 no strobe on unmapped write", 32'(stb_cycles), 32'd0);

    do_write(24'h010042, 32'h3333_4444, 1'b1);
    chk(stb_cycles == 0, "R10 no strobe with cs high", 32'(stb_cycles), 32'd0);

    addr = 24'h020099; oe_n = 1'b0;
    cyc(10);
    chk(rdata == prev, "R10 no read with cs high", rdata, prev);
    oe_n = 1'b1;
    cyc(4);

    do_read(24'h020099, 32'h02A50099, prev);
    prev = 32'h02A50099;
    do_read(24'h020099, 32'h02A50099, prev);

    rst = 1'b1;
    cyc(1);
    chk(rdata == 32'h0, "R1 mid-run reset clears word", rdata, 32'h0);
    rst = 1'b0;
    cyc(1);
    chk(rdata == 32'h0, "R1 word stays clear", rdata, 32'h0);

    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
    finish_run();
  end
endmodule